// File: doc/BRIEF.md
# Guarded Decode-Method Configuration Register

This block is a small memory-mapped configuration register. It holds a multi-bit decode-method field that a downstream bit-stream decoder reads, plus a group of plain configuration bits. The decode method must not change while a stream is in flight. Software writes to that field are therefore gated by a separate guard bit, and they are staged rather than applied at once.

A write to the configuration register while the guard is set loads the method into a staging copy. The decoder keeps seeing the old method. The staged value moves to the active output only in the cycle in which software clears the guard. The plain configuration bits in the same register take effect immediately on every write, whether the guard is set or not.

The bus is a single-cycle register port. A write happens in the cycle its strobe is high. Read data is registered and appears one cycle after the address is presented.

Top module: `guarded_cfg_reg`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the active method, the staged method, the guard bit and the plain bits are all zero, and `bus_rdata` is zero.
- R2: A write to address 0 while the guard bit is 0 leaves the staged method and the active method unchanged. `pend_o` stays as it was.
- R3: A write to address 0 while the guard bit is 1 loads `bus_wdata[METHOD_W-1:0]` into the staged method. `method_o` does not change at that write.
- R4: Every write to address 0 loads `bus_wdata[METHOD_W+MISC_W-1:METHOD_W]` into `misc_o` on that clock edge, whatever the guard bit holds.
- R5: A write to address 1 with `bus_wdata[0]`=0 while the guard bit is 1 copies the staged method to `method_o` on that same edge. After that edge, `pend_o` is 0.
- R6: A write of 0 to the guard while it is already 0 does not change `method_o`. A write of 1 while it is already 1 does not change `method_o` either. `method_o` changes only through R5.
- R7: Reading address 0 returns the active method in bits [METHOD_W-1:0] and the plain bits in bits [METHOD_W+MISC_W-1:METHOD_W]. All other bits are zero. It never returns the staged method.
- R8: Reading address 1 returns the guard bit in bit 0. Reading address 2 returns, in bit 0, whether the staged method differs from the active one. Reading address 3 returns zero. Read data appears the cycle after the address is presented.
- R9: `pend_o` is 1 exactly when the staged method differs from the active method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address (0 config, 1 guard, 2 status) |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| method_o | output | METHOD_W | Active decode method for the decoder |
| misc_o | output | MISC_W | Plain configuration bits |
| pend_o | output | 1 | Staged method differs from active |

## Verification
Two events can fall in the same cycle: the commit that happens when the guard clears, and a readback of the configuration register. The bench provokes this by presenting address 0 in the cycle directly after the guard-clearing write. It requires the registered read to return the newly committed method, not the old one. The bench also reads the guard and status registers straight after a commit, to confirm the guard reads 0 and the outstanding flag is gone. Random sequences then mix guarded and unguarded writes, redundant guard writes and reads, and every outcome is compared against a bench model of the staged copy and the active copy.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CFG   = 2'd0;
  localparam logic [ADDR_W-1:0] A_GUARD = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
endpackage

// File: rtl/gcr_guard.sv
// Guard bit and release detection.
module gcr_guard (
  input  logic clk,
  input  logic rst,
  input  logic wr_guard,
  input  logic wbit,
  output logic guard_q,
  output logic commit
);
  // High for the one edge in which the guard goes from 1 to 0.
  assign commit = wr_guard & ~wbit & guard_q;

  always_ff @(posedge clk) begin
    if (rst)           guard_q <= 1'b0;
    else if (wr_guard) guard_q <= wbit;
  end
endmodule

// File: rtl/gcr_field.sv
// Staged and active copies of the protected field.
module gcr_field #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] wval,
  input  logic         commit,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (load)   stage_q <= wval;
      if (commit) act_q   <= stage_q;
    end
  end
endmodule

// File: rtl/gcr_readback.sv
// Registered read multiplexer.
module gcr_readback #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned METHOD_W = 3,
  parameter int unsigned MISC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [gcr_pkg::ADDR_W-1:0] addr,
  input  logic [METHOD_W-1:0]       act,
  input  logic [MISC_W-1:0]         misc,
  input  logic                      guard,
  input  logic                      differs,
  output logic [DATA_W-1:0]         rdata
);
  localparam int unsigned CFG_W = METHOD_W + MISC_W;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    case (addr)
      gcr_pkg::A_CFG:   nxt[CFG_W-1:0] = {misc, act};
      gcr_pkg::A_GUARD: nxt[0] = guard;
      gcr_pkg::A_STAT:  nxt[0] = differs;
      default:          nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/guarded_cfg_reg.sv
module guarded_cfg_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned METHOD_W = 3,
  parameter int unsigned MISC_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [gcr_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [METHOD_W-1:0]        method_o,
  output logic [MISC_W-1:0]          misc_o,
  output logic                       pend_o
);
  localparam int unsigned CFG_W = METHOD_W + MISC_W;

  logic wr_cfg, wr_guard, guard_q, commit;
  logic [METHOD_W-1:0] stage_q, act_q;
  logic [MISC_W-1:0]   misc_q;

  assign wr_cfg   = bus_wr && (bus_addr == gcr_pkg::A_CFG);
  assign wr_guard = bus_wr && (bus_addr == gcr_pkg::A_GUARD);

  gcr_guard u_guard (
    .clk(clk), .rst(rst), .wr_guard(wr_guard), .wbit(bus_wdata[0]),
    .guard_q(guard_q), .commit(commit)
  );

  gcr_field #(.W(METHOD_W)) u_field (
    .clk(clk), .rst(rst), .load(wr_cfg && guard_q),
    .wval(bus_wdata[METHOD_W-1:0]), .commit(commit),
    .stage_q(stage_q), .act_q(act_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         misc_q <= '0;
    else if (wr_cfg) misc_q <= bus_wdata[CFG_W-1:METHOD_W];
  end

  gcr_readback #(.DATA_W(DATA_W), .METHOD_W(METHOD_W), .MISC_W(MISC_W)) u_rb (
    .clk(clk), .rst(rst), .addr(bus_addr), .act(act_q), .misc(misc_q),
    .guard(guard_q), .differs(pend_o), .rdata(bus_rdata)
  );

  assign method_o = act_q;
  assign misc_o   = misc_q;
  assign pend_o   = (stage_q != act_q);
endmodule

// File: rtl/guarded_cfg_reg_chk.sv
module guarded_cfg_reg_chk #(
  parameter int unsigned METHOD_W = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic [gcr_pkg::ADDR_W-1:0] bus_addr,
  input logic                       wbit0,
  input logic                       guard_q,
  input logic [METHOD_W-1:0]        stage_q,
  input logic [METHOD_W-1:0]        method_o,
  input logic                       pend_o
);
  logic rel;
  assign rel = bus_wr && bus_addr == gcr_pkg::A_GUARD && !wbit0 && guard_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (method_o == '0 && stage_q == '0 && !guard_q));

  assert_locked_field_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == gcr_pkg::A_CFG && !guard_q) |=> $stable(stage_q));

  assert_only_release_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !rel |=> $stable(method_o));

  assert_release_commits_R5: assert property (@(posedge clk) disable iff (rst)
    rel |=> (method_o == $past(stage_q)));

  assert_clean_after_release_R9: assert property (@(posedge clk) disable iff (rst)
    rel |=> !pend_o);
endmodule

bind guarded_cfg_reg guarded_cfg_reg_chk #(.METHOD_W(METHOD_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .guard_q(guard_q), .stage_q(stage_q),
  .method_o(method_o), .pend_o(pend_o)
);

// File: tb/guarded_cfg_reg_tb_top.sv
`timescale 1ns/1ps
module guarded_cfg_reg_tb_top;
  localparam int DW = 32, MW = 3, XW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] bus_addr;
  logic bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [MW-1:0] method_o;
  logic [XW-1:0] misc_o;
  logic pend_o;

  int n_chk = 0, n_bad = 0;

  // Bench model
  logic m_guard;
  logic [MW-1:0] m_stage, m_act;
  logic [XW-1:0] m_misc;

  always #2 clk = ~clk;

  guarded_cfg_reg #(.DATA_W(DW), .METHOD_W(MW), .MISC_W(XW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .method_o(method_o),
    .misc_o(misc_o), .pend_o(pend_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      2'd0: v[MW+XW-1:0] = {m_misc, m_act};
      2'd1: v[0] = m_guard;
      2'd2: v[0] = (m_stage != m_act);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check({tag, " method_o"}, DW'(method_o), DW'(m_act));
    check({tag, " misc_o"},   DW'(misc_o),   DW'(m_misc));
    check({tag, " pend_o R9"}, DW'(pend_o),  DW'(m_stage != m_act));
  endtask

  // Drive at negedge; the write lands on the following posedge.
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd0: begin
        m_misc = d[MW+XW-1:MW];
        if (m_guard) m_stage = d[MW-1:0];
      end
      2'd1: begin
        if (m_guard && !d[0]) m_act = m_stage;
        m_guard = d[0];
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    logic [DW-1:0] e;
    e = exp_read(a);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    check(tag, bus_rdata, e);
  endtask

  function automatic logic [DW-1:0] cfgw(input logic [XW-1:0] x, input logic [MW-1:0] m);
    logic [DW-1:0] v = '0;
    v[MW+XW-1:0] = {x, m};
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_0a17;
    void'($urandom(seed));
    m_guard = 0; m_stage = '0; m_act = '0; m_misc = '0;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 method", DW'(method_o), '0);
    check("R1 misc", DW'(misc_o), '0);
    check("R1 rdata", bus_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R1 after release");

    // R2: unguarded write leaves field, R4 misc still updates
    wr(2'd0, cfgw(8'hA5, 3'd5));
    check_outs("R2/R4 unguarded");
    rd(2'd2, "R2 status clear");
    // R3: guarded write stages only
    wr(2'd1, 32'd1);
    rd(2'd1, "R8 guard readback");
    wr(2'd0, cfgw(8'h3C, 3'd6));
    check_outs("R3 staged only");
    rd(2'd0, "R7 reads active not staged");
    rd(2'd2, "R8 status pending");
    // R6: redundant set keeps method
    wr(2'd1, 32'd1);
    check_outs("R6 redundant set");
    // R5: release commits, read in the next cycle sees it
    wr(2'd1, 32'd0);
    check_outs("R5 commit");
    rd(2'd0, "R5/R7 read right after commit");
    rd(2'd1, "R8 guard cleared");
    rd(2'd2, "R9 status clear after commit");
    rd(2'd3, "R8 unused address");
    // R6: redundant clear
    wr(2'd1, 32'd0);
    check_outs("R6 redundant clear");
    // R6: release with no staged write keeps value
    wr(2'd1, 32'd1);
    wr(2'd1, 32'd0);
    check_outs("R6 empty release");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 5);
      logic [1:0] a = 2'($urandom_range(0, 3));
      case (op)
        0, 1: wr(2'd0, $urandom());
        2:    wr(2'd1, DW'($urandom_range(0, 1)));
        3:    wr(a, $urandom());
        default: rd(a, "R7/R8 random read");
      endcase
      check_outs("R2/R3/R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule